// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the power-control register of a small 8-bit processor and derives the clocks that the core and its peripherals receive. Software writes the register to put the chip into one of two sleep states. In the light state (idle) only the processor clock stops, so timers and serial units keep working. In the deep state (power-down) the oscillator-enable output is dropped and both derived clocks stop at a low level. The register also carries two flag bits that software can use freely. Mode entry and mode exit never disturb them.

Leaving a sleep state depends on how it was left:

- **Idle, left by an enabled interrupt:** the processor clock returns one cycle after the interrupt is sampled.
- **Idle, left by reset:** the idle bit clears the moment reset rises, before any clock edge.
- **Power-down, left by an interrupt:** the interrupt turns the oscillator back on at once. The clocks are then held off for a fixed, parameterised number of settle cycles.
- **Power-down, left by reset:** the reset pulse itself covers the settle time.

Both clocks pass through a gate made of a latch and an AND, so they never produce a shortened pulse.

Top module: `pwr_mode_ctl`

## Requirements
- R1: Register layout: bit 0 is the idle request, bit 1 the power-down request, bit 2 is flag A and bit 3 is flag B. Bits 7:4 read as 0. A write is taken only while `mode_o` is 2'b00 (run). A write made in any other mode changes nothing.
- R2: A write taken with bit 0 = 1 and bit 1 = 0 sets the idle bit. From the next cycle `mode_o` reads 2'b01. `cpu_clk` shows no rising edge after the edge that took the write, while `per_clk` keeps one rising edge per source cycle.
- R3: A write taken with bit 1 = 1 enters power-down (`mode_o` = 2'b10) whatever bit 0 holds. The idle bit stays 0, so leaving power-down returns to run and never to idle.
- R4: In idle, `irq` sampled high clears the idle bit. `mode_o` reads 2'b00 one cycle later and `cpu_clk` edges resume.
- R5: A rising `rst` clears the idle bit at once, with no clock edge needed. `mode_o` then reads 2'b00 and `cpu_clk` shows no partial pulse.
- R6: In power-down, with `irq` and `rst` low, `osc_en` is 0 and neither `cpu_clk` nor `per_clk` toggles.
- R7: The two flag bits change only through a taken write or reset. Entry into and exit from either sleep mode leave them unchanged.
- R8: In power-down, `osc_en` is 1 for as long as `irq` is high. The edge that samples `irq` clears the power-down bit. `mode_o` then stays 2'b10 with both clocks stopped for SETTLE_CYC cycles, and reads 2'b00 after that.
- R9: In power-down, `osc_en` is 1 for as long as `rst` is high. Reset clears the power-down bit, and both clocks run right after reset is released, with no settle wait.
- R10: After reset the register reads 0x00, `mode_o` is 2'b00, `osc_en` is 1, and both clocks toggle every source cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock, the source of both gated clocks |
| rst | input | 1 | Active-high reset; also clears the idle bit asynchronously |
| wr_en | input | 1 | Processor write strobe for the power-control register |
| wr_data | input | 8 | Write data |
| irq | input | 1 | Enabled interrupt request that wakes the block |
| rd_data | output | 8 | Register read value |
| mode_o | output | 2 | Current mode: 00 run, 01 idle, 10 power-down (includes settle) |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk | output | 1 | Gated processor clock |
| per_clk | output | 1 | Gated peripheral clock |

## Verification
The assertions check on every cycle the following:

- A write with the power-down bit set wins over the idle bit.
- An interrupt in idle returns the block to run on the next cycle.
- The flag bits stay still unless a write is taken.
- Writes made outside run are ignored.
- The oscillator enable stays low in power-down.
- An interrupt in power-down clears the bit but keeps the mode reported as power-down.

The bench scenarios cover what only shows over time. They count clock edges in each mode to confirm that idle stops only the processor clock. They confirm that the settle window ends after exactly SETTLE_CYC cycles. They also raise reset in the high phase of the clock, to show that the idle bit clears before any edge and that no partial processor-clock pulse appears.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_IDLE  = 0;
  localparam int BIT_PD    = 1;
  localparam int BIT_FLAGA = 2;
  localparam int BIT_FLAGB = 3;
  localparam int NUM_GCLK  = 2;
  localparam int GCLK_CPU  = 0;
  localparam int GCLK_PER  = 1;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_PD   = 2'b10
  } pmode_e;
endpackage

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_accept,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq,
  output logic             idle_q,
  output logic             pd_q,
  output logic [1:0]       flags_q
);
  // idle bit: cleared by reset without waiting for a clock edge
  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      idle_q <= 1'b0;
    else if (idle_q && irq)
      idle_q <= 1'b0;
    else if (wr_accept)
      idle_q <= wr_data[BIT_IDLE] & ~wr_data[BIT_PD];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q    <= 1'b0;
      flags_q <= 2'b00;
    end else begin
      if (pd_q && irq)
        pd_q <= 1'b0;
      else if (wr_accept)
        pd_q <= wr_data[BIT_PD];
      if (wr_accept)
        flags_q <= {wr_data[BIT_FLAGB], wr_data[BIT_FLAGA]};
    end
  end
endmodule

// File: rtl/pwr_settle_cnt.sv
module pwr_settle_cnt #(
  parameter int SETTLE_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= CW'(SETTLE_CYC);
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate (
  input  logic clk_src,
  input  logic en,
  output logic clk_out
);
  logic en_l;

  // enable may only change while the source clock is low
  always_latch begin
    if (!clk_src)
      en_l = en;
  end

  assign clk_out = clk_src & en_l;
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_ctl_pkg::*;
#(
  parameter int SETTLE_CYC = 1024
) (
  input  logic             clk_osc,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq,
  output logic [REG_W-1:0] rd_data,
  output logic [1:0]       mode_o,
  output logic             osc_en,
  output logic             cpu_clk,
  output logic             per_clk
);
  logic          idle_q, pd_q, busy, wr_accept, pd_exit;
  logic [1:0]    flags_q;
  pmode_e        mode;
  logic [NUM_GCLK-1:0] gate_en, gclk;

  always_comb begin
    if (pd_q || busy)
      mode = MODE_PD;
    else if (idle_q)
      mode = MODE_IDLE;
    else
      mode = MODE_RUN;
  end

  assign wr_accept = wr_en && (mode == MODE_RUN);
  assign pd_exit   = pd_q && irq && !rst;

  pwr_ctl_reg u_reg (
    .clk       (clk_osc),
    .rst       (rst),
    .wr_accept (wr_accept),
    .wr_data   (wr_data),
    .irq       (irq),
    .idle_q    (idle_q),
    .pd_q      (pd_q),
    .flags_q   (flags_q)
  );

  pwr_settle_cnt #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk  (clk_osc),
    .rst  (rst),
    .load (pd_exit),
    .busy (busy)
  );

  // wake sources restart the oscillator without waiting for a clock
  assign osc_en = !pd_q || irq || rst;

  assign gate_en[GCLK_CPU] = (mode == MODE_RUN);
  assign gate_en[GCLK_PER] = !(pd_q || busy);

  for (genvar g = 0; g < NUM_GCLK; g++) begin : g_gate
    pwr_clk_gate u_gate (
      .clk_src (clk_osc),
      .en      (gate_en[g]),
      .clk_out (gclk[g])
    );
  end

  assign cpu_clk = gclk[GCLK_CPU];
  assign per_clk = gclk[GCLK_PER];

  always_comb begin
    rd_data            = '0;
    rd_data[BIT_IDLE]  = idle_q;
    rd_data[BIT_PD]    = pd_q;
    rd_data[BIT_FLAGA] = flags_q[0];
    rd_data[BIT_FLAGB] = flags_q[1];
  end

  assign mode_o = mode;
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk (
  input logic       clk_osc,
  input logic       rst,
  input logic       wr_en,
  input logic       wr_pd,
  input logic       irq,
  input logic [3:0] rd_lo,
  input logic [1:0] mode_o,
  input logic       osc_en
);
  logic taken;
  assign taken = wr_en && (mode_o == 2'b00);

  AST_WR_IGNORED: assert property (@(posedge clk_osc) disable iff (rst)
    (wr_en && mode_o != 2'b00 && !irq) |=> $stable(rd_lo)); // R1

  AST_PD_WINS: assert property (@(posedge clk_osc) disable iff (rst)
    (taken && wr_pd) |=> (mode_o == 2'b10 && !rd_lo[0])); // R3

  AST_IDLE_IRQ_EXIT: assert property (@(posedge clk_osc) disable iff (rst)
    (mode_o == 2'b01 && irq) |=> (mode_o == 2'b00)); // R4

  AST_RST_IDLE_CLR: assert property (@(posedge clk_osc)
    (rst && $past(rst)) |-> !rd_lo[0]); // R5

  AST_PD_OSC_OFF: assert property (@(posedge clk_osc) disable iff (rst)
    (rd_lo[1] && !irq) |-> !osc_en); // R6

  AST_FLAGS_HOLD: assert property (@(posedge clk_osc) disable iff (rst)
    !taken |=> $stable(rd_lo[3:2])); // R7

  AST_PD_SETTLE: assert property (@(posedge clk_osc) disable iff (rst)
    (rd_lo[1] && irq) |=> (mode_o == 2'b10 && !rd_lo[1])); // R8
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk u_chk (
  .clk_osc (clk_osc),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_pd   (wr_data[1]),
  .irq     (irq),
  .rd_lo   (rd_data[3:0]),
  .mode_o  (mode_o),
  .osc_en  (osc_en)
);

// File: tb/tb_pwr_mode_ctl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctl;
  localparam int SETTLE = 1024;
  localparam int NV = 7;
  // {wr_data[25:18], mode[17:16], rd[15:8], cpu edges[7:4], per edges[3:0]}
  localparam logic [25:0] VEC [NV] = '{
    {8'h04, 2'b00, 8'h04, 4'd8, 4'd8},   // R1 R7 flag A only
    {8'h01, 2'b01, 8'h01, 4'd0, 4'd8},   // R2 idle
    {8'h0D, 2'b01, 8'h0D, 4'd0, 4'd8},   // R2 R7 idle with flags
    {8'h02, 2'b10, 8'h02, 4'd0, 4'd0},   // R6 power-down
    {8'h03, 2'b10, 8'h02, 4'd0, 4'd0},   // R3 both bits
    {8'h0B, 2'b10, 8'h0A, 4'd0, 4'd0},   // R3 R7 both bits, flag B
    {8'hF8, 2'b00, 8'h08, 4'd8, 4'd8}    // R1 upper bits read 0
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, irq = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] mode_o;
  logic osc_en, cpu_clk, per_clk;
  int n_chk = 0, n_fail = 0, cpu_n = 0, per_n = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_mode_ctl #(.SETTLE_CYC(SETTLE)) dut (
    .clk_osc(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .irq(irq),
    .rd_data(rd_data), .mode_o(mode_o), .osc_en(osc_en),
    .cpu_clk(cpu_clk), .per_clk(per_clk)
  );

  always @(posedge cpu_clk) cpu_n++;
  always @(posedge per_clk) per_n++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse_irq();
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
  endtask

  task automatic window8();
    cpu_n = 0; per_n = 0;
    negs(8);
  endtask

  initial begin
    negs(4);
    rst = 1'b0;
    // R10 reset state
    chk("R10 rd", rd_data, 8'h00);
    chk("R10 mode", mode_o, 2'b00);
    chk("R10 osc_en", osc_en, 1'b1);
    window8();
    chk("R10 cpu edges", cpu_n, 8);
    chk("R10 per edges", per_n, 8);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][25:18]);
      window8();
      chk("R1/R2/R3 mode", mode_o, VEC[i][17:16]);
      chk("R1/R3/R7 rd", rd_data, VEC[i][15:8]);
      chk("R2/R6 cpu edges", cpu_n, VEC[i][7:4]);
      chk("R2/R6 per edges", per_n, VEC[i][3:0]);
      chk("R6 osc_en", osc_en, VEC[i][17:16] != 2'b10);
      if (VEC[i][17:16] != 2'b00) begin
        pulse_irq();
        if (VEC[i][17:16] == 2'b10) negs(SETTLE);
        chk("R3/R4/R7 exit mode", mode_o, 2'b00);
        chk("R3/R4/R7 exit rd", rd_data, {4'h0, VEC[i][13:10], 2'b00});
      end
    end

    // R1 write during idle is ignored, R4 interrupt exit
    wr(8'h01);
    wr(8'h02);
    chk("R1 idle write ignored mode", mode_o, 2'b01);
    chk("R1 idle write ignored rd", rd_data, 8'h01);
    pulse_irq();
    chk("R4 idle exit mode", mode_o, 2'b00);
    window8();
    chk("R4 cpu edges after exit", cpu_n, 8);

    // R8 interrupt exit from power-down with settle
    wr(8'h0E);
    negs(2);
    irq = 1'b1;
    #1;
    chk("R8 osc_en on irq", osc_en, 1'b1);
    @(negedge clk);
    irq = 1'b0;
    cpu_n = 0; per_n = 0;
    negs(SETTLE - 2);
    wr(8'h01);
    chk("R8 settle mode", mode_o, 2'b10);
    chk("R1 R8 settle rd", rd_data, 8'h0C);
    chk("R8 settle cpu edges", cpu_n, 0);
    chk("R8 settle per edges", per_n, 0);
    negs(1);
    chk("R8 run after settle", mode_o, 2'b00);
    chk("R7 flags after settle", rd_data, 8'h0C);

    // R5 asynchronous idle clear by reset in the high phase
    wr(8'h05);
    @(posedge clk);
    #2;
    rst = 1'b1;
    #1;
    chk("R5 idle bit clear", rd_data, 8'h04);
    chk("R5 mode", mode_o, 2'b00);
    chk("R5 no runt on cpu_clk", cpu_clk, 1'b0);
    @(negedge clk);
    negs(2);
    rst = 1'b0;
    window8();
    chk("R5 cpu edges after reset", cpu_n, 8);

    // R9 reset exit from power-down
    wr(8'h02);
    negs(2);
    chk("R9 osc_en low before reset", osc_en, 1'b0);
    rst = 1'b1;
    #1;
    chk("R9 osc_en on reset", osc_en, 1'b1);
    negs(3);
    rst = 1'b0;
    chk("R9 mode", mode_o, 2'b00);
    chk("R9 rd", rd_data, 8'h00);
    window8();
    chk("R9 cpu edges", cpu_n, 8);
    chk("R9 per edges", per_n, 8);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule